// File: doc/BRIEF.md
# Resumable Framed Serial Read Port

This block is the slave side of a serial read path on a converter-style device. An external master owns the serial clock and an active-low frame strobe. When the strobe falls at the start of a word, the port captures a select input. That input chooses either the latest conversion result or a control/calibration word, which the port then sends out MSB first on a data line with a separate driver enable. The port also keeps an active-low ready flag. The flag drops when a fresh conversion result is loaded and rises once the whole result word has been read.

The master may raise the strobe in the middle of a word and lower it again later. The driver turns off while the strobe is high, and the port keeps its place in the word. A conversion result that arrives while a result read is under way is held back, so the word in flight is not corrupted. The held result is loaded when that read ends. All pin inputs are sampled on the system clock, and every output is a register, so each response follows its cause by one system clock.

Top module: `rfsp_read_port`

## Requirements
- R1: On the first frame strobe fall of a word, the next system clock sets the driver enable and puts bit 23 (the MSB) of the selected word on the data line.
- R2: Each falling serial clock edge seen while the strobe is low moves the data line to the next lower bit, so a word leaves MSB first.
- R3: After 23 falling edges the LSB is on the line. The 24th falling edge ends the word, turns the driver off, and, for a result read, sets the ready flag high.
- R4: Whenever the ready flag rises, the driver enable is low.
- R5: A strobe rise in mid-word turns the driver off and keeps the bit position. The next strobe fall turns the driver on again with the same bit on the line.
- R6: During a result read the ready flag stays low until the word is complete, however often the strobe toggles.
- R7: With select = 0 the port sends the control/calibration word as exactly 24 bits. Such a read never changes the ready flag, and a result arriving during it drives the flag low at once.
- R8: The select input is sampled only at the start of a word (1 = conversion result, 0 = control/calibration). Changing it in mid-word has no effect on the bits sent or on the ready flag.
- R9: A result arriving during a result read does not change the word being sent. It is loaded when that word ends, the ready flag stays low, and the next result read returns it.
- R10: A result arriving while no result read is under way is loaded, and the ready flag is low on the next system clock.
- R11: A synchronous reset clears the bit position, turns the driver off and sets the ready flag high. A read that starts after the reset begins at the MSB.
- R12: Falling serial clock edges that occur while the strobe is high do not move the bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master, idles low |
| frame_n | input | 1 | Active-low read frame strobe |
| reg_sel | input | 1 | Word select sampled at word start: 1 result, 0 control/calibration |
| conv_valid | input | 1 | One-cycle pulse: a new conversion result is on conv_word |
| conv_word | input | 24 | New conversion result |
| ctl_word | input | 24 | Control/calibration word to send when select is 0 |
| sdata | output | 1 | Serial data bit (meaningful only while sdata_oe is high) |
| sdata_oe | output | 1 | Driver enable for the serial data line (low means high impedance) |
| ready_n | output | 1 | Active-low data-ready flag |

## Verification
The hardest case to reach from the ports is a conversion result that lands in the middle of a result read which has also been paused. The bench reaches it with directed reads. Each one counts serial clock pulses up to a chosen bit index and then pulses conv_valid, or raises the strobe, issues stray serial clock pulses, and lowers the strobe again. It then checks the resumed bit, the unchanged word in flight, the ready flag that stays low, and the held result returned by the following read. A reset issued partway through a word verifies that the position is really cleared.

// File: rtl/rfsp_pkg.sv
package rfsp_pkg;
  // Word selection captured at the first strobe fall of a word.
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } rfsp_sel_e;
endpackage

// File: rtl/rfsp_sampler.sv
// Registers the previous value of each pin so that edges can be found
// by comparing the current input against it.
module rfsp_sampler #(
  parameter int          N    = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] prev
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev[g] <= IDLE[g];
      else     prev[g] <= din[g];
    end
  end
endmodule

// File: rtl/rfsp_bit_counter.sv
// Position within the word and the word-in-progress flag.
module rfsp_bit_counter #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             advance,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             at_last
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (advance) begin
      if (at_last) begin
        cnt    <= '0;
        active <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfsp_shifter.sv
// Holds the word in flight and the driver enable for the data line.
module rfsp_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  input  logic              drv_on,
  input  logic              drv_off,
  output logic              sdata,
  output logic              sdata_oe
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)        shreg <= '0;
    else if (load)  shreg <= load_word;
    else if (shift) shreg <= {shreg[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)          sdata_oe <= 1'b0;
    else if (drv_on)  sdata_oe <= 1'b1;
    else if (drv_off) sdata_oe <= 1'b0;
  end

  assign sdata = shreg[WORD_W-1];
endmodule

// File: rtl/rfsp_result_hold.sv
// Output data register, one-deep holding slot and ready flag.
module rfsp_result_hold #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [WORD_W-1:0] conv_word,
  input  logic              busy,
  input  logic              done,
  output logic [WORD_W-1:0] data_word,
  output logic              ready_n
);
  logic              pend;
  logic [WORD_W-1:0] pend_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_word <= '0;
      pend_word <= '0;
      pend      <= 1'b0;
      ready_n   <= 1'b1;
    end else if (done) begin
      pend <= 1'b0;
      if (conv_valid) begin
        data_word <= conv_word;
        ready_n   <= 1'b0;
      end else if (pend) begin
        data_word <= pend_word;
        ready_n   <= 1'b0;
      end else begin
        ready_n   <= 1'b1;
      end
    end else if (conv_valid) begin
      if (busy) begin
        pend      <= 1'b1;
        pend_word <= conv_word;
      end else begin
        data_word <= conv_word;
        ready_n   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rfsp_read_port.sv
module rfsp_read_port
  import rfsp_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              frame_n,
  input  logic              reg_sel,
  input  logic              conv_valid,
  input  logic [WORD_W-1:0] conv_word,
  input  logic [WORD_W-1:0] ctl_word,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              ready_n
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [1:0]        pin_prev;
  logic              sclk_prev, frame_prev;
  logic              frm_fall, frm_rise, sclk_fall;
  logic              start, resume, shift_evt, last;
  logic [CNT_W-1:0]  bit_idx;
  logic              word_active, at_last;
  rfsp_sel_e         sel_q;
  logic              data_busy, data_done;
  logic [WORD_W-1:0] data_word, load_word;

  rfsp_sampler #(.N(2), .IDLE(2'b10)) sampler_i (
    .clk (clk),
    .rst (rst),
    .din ({frame_n, sclk}),
    .prev(pin_prev)
  );

  assign {frame_prev, sclk_prev} = pin_prev;
  assign frm_fall  = frame_prev & ~frame_n;
  assign frm_rise  = ~frame_prev & frame_n;
  assign sclk_fall = sclk_prev & ~sclk;

  assign start     = frm_fall & ~word_active;
  assign resume    = frm_fall & word_active;
  assign shift_evt = sclk_fall & ~frame_n & word_active & ~frm_fall;
  assign last      = shift_evt & at_last;

  always_ff @(posedge clk) begin
    if (rst)        sel_q <= SEL_CTRL;
    else if (start) sel_q <= rfsp_sel_e'(reg_sel);
  end

  assign data_busy = (word_active & (sel_q == SEL_DATA)) | (start & reg_sel);
  assign data_done = last & (sel_q == SEL_DATA);
  assign load_word = reg_sel ? data_word : ctl_word;

  rfsp_bit_counter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) counter_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .advance(shift_evt),
    .cnt    (bit_idx),
    .active (word_active),
    .at_last(at_last)
  );

  rfsp_shifter #(.WORD_W(WORD_W)) shifter_i (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_word(load_word),
    .shift    (shift_evt & ~at_last),
    .drv_on   (start | resume),
    .drv_off  (frm_rise | last),
    .sdata    (sdata),
    .sdata_oe (sdata_oe)
  );

  rfsp_result_hold #(.WORD_W(WORD_W)) hold_i (
    .clk       (clk),
    .rst       (rst),
    .conv_valid(conv_valid),
    .conv_word (conv_word),
    .busy      (data_busy),
    .done      (data_done),
    .data_word (data_word),
    .ready_n   (ready_n)
  );
endmodule

// File: rtl/rfsp_read_port_chk.sv
module rfsp_read_port_chk #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_n,
  input logic             sdata_oe,
  input logic             ready_n,
  input logic [CNT_W-1:0] bit_idx,
  input logic             word_active
);
  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (ready_n && !sdata_oe && bit_idx == '0));

  assert_frame_fall_drives_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_n) |=> sdata_oe);

  assert_frame_rise_off_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_n) |=> !sdata_oe);

  assert_pause_keeps_pos_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_n) |=> $stable(bit_idx));

  assert_ready_rise_off_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_n) |-> !sdata_oe);

  assert_ready_rise_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_n) |-> (!word_active && bit_idx == '0));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= CNT_W'(WORD_W - 1));
endmodule

bind rfsp_read_port rfsp_read_port_chk #(.WORD_W(WORD_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .frame_n    (frame_n),
  .sdata_oe   (sdata_oe),
  .ready_n    (ready_n),
  .bit_idx    (bit_idx),
  .word_active(word_active)
);

// File: tb/rfsp_read_port_tb_top.sv
module rfsp_read_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        frame_n = 1'b1;
  logic        reg_sel = 1'b1;
  logic        conv_valid = 1'b0;
  logic [23:0] conv_word = '0;
  logic [23:0] ctl_word = '0;
  logic        sdata, sdata_oe, ready_n;

  int errors = 0;
  int checks = 0;
  logic [23:0] got;

  always #10 clk = ~clk;

  rfsp_read_port #(.WORD_W(24)) dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .frame_n(frame_n), .reg_sel(reg_sel),
    .conv_valid(conv_valid), .conv_word(conv_word), .ctl_word(ctl_word),
    .sdata(sdata), .sdata_oe(sdata_oe), .ready_n(ready_n)
  );

  // Table fields: [48] select, [47:24] word, [23:0] unused low half holds pause index in [4:0]
  localparam int NV = 6;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 24'hA5C3F0, 24'd31},
    {1'b0, 24'h5A0FF1, 24'd0},
    {1'b1, 24'h800001, 24'd7},
    {1'b0, 24'hC0FFEE, 24'd23},
    {1'b1, 24'h7FFFFE, 24'd23},
    {1'b1, 24'h000000, 24'd12}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; step();
    sclk = 1'b0; step();
  endtask

  task automatic conv(input logic [23:0] w);
    conv_word = w; conv_valid = 1'b1; step();
    conv_valid = 1'b0;
  endtask

  task automatic start_read(input logic sel);
    reg_sel = sel; frame_n = 1'b0; step();
    check("R1 driver on at frame fall", sdata_oe, 1'b1);
  endtask

  // Reads one word; optional pause at bit pause_at, optional result at bit conv_at.
  task automatic read_word(input logic is_data, input logic [23:0] exp, input int pause_at,
                           input int conv_at, input logic [23:0] conv_val,
                           output logic [23:0] w);
    w = '0;
    for (int i = 0; i < 24; i++) begin
      if (i == 0) check("R1 MSB presented", sdata, exp[23]);
      if (i == pause_at) begin
        frame_n = 1'b1; step();
        check("R5 driver off on pause", sdata_oe, 1'b0);
        if (is_data) check("R6 ready low while paused", ready_n, 1'b0);
        sclk_pulse(); sclk_pulse();
        frame_n = 1'b0; step();
        check("R5 driver on at resume", sdata_oe, 1'b1);
        check("R12 R5 same bit after resume", sdata, exp[23-i]);
      end
      if (i == conv_at) begin
        conv(conv_val);
        check("R9 R7 ready low after new result", ready_n, 1'b0);
      end
      w[23-i] = sdata;
      sclk_pulse();
    end
    check("R3 driver off after final edge", sdata_oe, 1'b0);
    frame_n = 1'b1; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) step();
    check("R11 reset ready high", ready_n, 1'b1);
    check("R11 reset driver off", sdata_oe, 1'b0);
    rst = 1'b0; step();

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic        sel  = VEC[v][48];
      logic [23:0] word = VEC[v][47:24];
      int          pz   = int'(VEC[v][4:0]);
      if (sel) begin
        conv(word);
        check("R10 ready low after idle load", ready_n, 1'b0);
      end else begin
        ctl_word = word;
      end
      start_read(sel);
      read_word(sel, word, pz, 99, '0, got);
      check("R2 word shifted MSB first", got, word);
      if (sel) check("R3 ready high after result read", ready_n, 1'b1);
      else     check("R7 ctrl read leaves ready", ready_n, 1'b1);
    end

    // R8: select changed mid-word
    conv(24'h3C960F);
    start_read(1'b1);
    reg_sel = 1'b0;
    ctl_word = 24'h111111;
    read_word(1'b1, 24'h3C960F, 5, 99, '0, got);
    check("R8 mid-word select ignored", got, 24'h3C960F);
    check("R8 ready high after result word", ready_n, 1'b1);

    // R9: result arriving during a paused result read
    conv(24'h123456);
    start_read(1'b1);
    read_word(1'b1, 24'h123456, 4, 10, 24'hFEDCBA, got);
    check("R9 word in flight unchanged", got, 24'h123456);
    check("R9 R6 ready stays low after word", ready_n, 1'b0);
    start_read(1'b1);
    read_word(1'b1, 24'hFEDCBA, 31, 99, '0, got);
    check("R9 held result returned", got, 24'hFEDCBA);
    check("R9 ready high after held word read", ready_n, 1'b1);

    // R7: result arriving during a control read
    ctl_word = 24'h0F0F0F;
    start_read(1'b0);
    read_word(1'b0, 24'h0F0F0F, 31, 6, 24'hABCDEF, got);
    check("R7 ctrl word sent", got, 24'h0F0F0F);
    check("R7 ready not raised by ctrl read", ready_n, 1'b0);
    start_read(1'b1);
    read_word(1'b1, 24'hABCDEF, 31, 99, '0, got);
    check("R7 result loaded during ctrl read", got, 24'hABCDEF);

    // R11: reset in mid-word, then a clean read from the MSB
    conv(24'h9ABC01);
    start_read(1'b1);
    for (int i = 0; i < 7; i++) sclk_pulse();
    rst = 1'b1; step();
    frame_n = 1'b1; step();
    check("R11 reset driver off", sdata_oe, 1'b0);
    check("R11 reset ready high", ready_n, 1'b1);
    rst = 1'b0; step();
    conv(24'h9ABC01);
    start_read(1'b1);
    read_word(1'b1, 24'h9ABC01, 31, 99, '0, got);
    check("R11 read after reset starts at MSB", got, 24'h9ABC01);

    summary();
  end
endmodule